// File: doc/BRIEF.md
# Operand Effective Address Generator

This block turns an operand specifier of a register-file-centred 16-bit processor into an address. The specifier holds an addressing mode, an 8-bit register selector, a 16-bit displacement or immediate field and an operand size. When the mode needs a base value, the block reads one word from the register file through a read port. It then returns one of three things: the effective address, the immediate value with a flag, or, for stack operations, both the stack slot address and the new stack pointer. A misaligned reference raises a fault and withholds the access.

Each request runs through a fixed three-state sequence, so every mode takes the same time. `ST_IDLE` waits for `start_i` and moves to `ST_READ` (transition *accept*). `ST_READ` drives the register read address, captures the base word and always moves to `ST_CALC` (transition *capture*). `ST_CALC` forms the result, registers it with a one-cycle `done_o` pulse and returns to `ST_IDLE` (transition *retire*). The decoder issues a request, waits for `done_o`, and uses `access_o` as permission to start the memory or register access. When `sp_we_o` is high, it writes `sp_next_o` back to the stack pointer word.

Top module: `operand_addr_gen`

## Requirements
- R1: A `start_i` seen on a rising edge while idle is accepted. `done_o` rises for exactly one cycle after the second rising edge that follows, and `busy_o` is high between acceptance and retirement. A `start_i` seen while busy is ignored: it changes neither the result of the request in flight nor the number of `done_o` pulses.
- R2: Mode 0 (register direct) gives an effective address equal to the 8-bit selector zero-extended to 16 bits. Mode 7 is decoded the same way.
- R3: Mode 1 (indirect) gives an effective address equal to the word read through the port at the selector.
- R4: Mode 2 (immediate) raises `imm_flag_o` and never faults. `ea_o` carries the low 8 bits of the field zero-extended for size 0 (byte), and the full 16-bit field for any other size.
- R5: Mode 3 (short indexed) adds bits 7:0 of the displacement, sign-extended, to the selected word. Bits 15:8 of the field are ignored, so the reach is -128 to +127 bytes.
- R6: Mode 4 (long indexed) adds the full 16-bit displacement to the selected word, without sign extension.
- R7: Register selector 0 supplies a base of zero whatever the read port returns. Long indexing through it therefore yields the displacement as an absolute address.
- R8: All address arithmetic wraps modulo 65536.
- R9: Mode 5 (push) reads the stack pointer at register address 18H. It returns stack pointer minus 2 both as the effective address and on `sp_next_o`, with `sp_we_o` high.
- R10: Mode 6 (pop) reads the stack pointer at 18H. It returns the old stack pointer as the effective address and the old value plus 2 on `sp_next_o`, with `sp_we_o` high.
- R11: Sizes are 0 byte, 1 word, 2 and 3 doubleword. A word reference needs address bit 0 clear, and a doubleword reference needs bits 1:0 clear. Push and pop are always checked as words. When the check fails, `align_fault_o` is high with `done_o`, `access_o` stays low and `sp_we_o` stays low.
- R12: While reset is asserted, and after it until the first result, `done_o`, `busy_o`, `access_o`, `sp_we_o`, `align_fault_o`, `imm_flag_o` are low and `ea_o` and `sp_next_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe, sampled while idle |
| mode_i | input | 3 | Addressing mode code |
| reg_sel_i | input | 8 | Register selector |
| disp_i | input | 16 | Displacement or immediate field |
| size_i | input | 2 | Operand size code |
| rf_addr_o | output | 8 | Register file read address |
| rf_data_i | input | 16 | Register file read data, same cycle |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle result strobe |
| ea_o | output | 16 | Effective address or immediate value |
| imm_flag_o | output | 1 | Result is an immediate operand |
| align_fault_o | output | 1 | Misaligned reference |
| access_o | output | 1 | Access permitted, with done_o |
| sp_next_o | output | 16 | Updated stack pointer |
| sp_we_o | output | 1 | Write sp_next_o back, with done_o |

## Verification
A stuck or skipped sequencer state shows up as a missing, doubled or mistimed `done_o` pulse, visible within three cycles of a start. A wrong base capture or register-zero override appears at once on `ea_o` for indirect and indexed requests that use distinctive register contents, including a register file that returns a nonzero word at address 0. Errors in stack pointer arithmetic appear on `sp_next_o` and on the address of the next push or pop. A broken alignment check shows as a fault on an aligned reference, or as an access granted on a misaligned one.

// File: rtl/eag_pkg.sv
`timescale 1ns/1ps
package eag_pkg;

    localparam int unsigned ADDR_W  = 16;
    localparam int unsigned SEL_W   = 8;
    localparam int unsigned SP_REG  = 8'h18;
    localparam int unsigned SP_STEP = 2;

    typedef enum logic [2:0] {
        AM_DIRECT   = 3'd0,
        AM_INDIRECT = 3'd1,
        AM_IMMED    = 3'd2,
        AM_SHORT    = 3'd3,
        AM_LONG     = 3'd4,
        AM_PUSH     = 3'd5,
        AM_POP      = 3'd6,
        AM_RSVD     = 3'd7
    } amode_e;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_DWORD = 2'd2,
        SZ_DWRD2 = 2'd3
    } osize_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_READ = 2'd1,
        ST_CALC = 2'd2
    } eag_state_e;

    function automatic logic is_stack(amode_e m);
        return (m == AM_PUSH) || (m == AM_POP);
    endfunction

endpackage

// File: rtl/eag_base_sel.sv
`timescale 1ns/1ps
module eag_base_sel
    import eag_pkg::*;
#(
    parameter int unsigned ADDR_W_P   = ADDR_W,
    parameter int unsigned SEL_W_P    = SEL_W,
    parameter int unsigned SP_REG_P   = SP_REG,
    parameter bit          ZERO_REG_P = 1'b1
) (
    input  amode_e              mode_i,
    input  logic [SEL_W_P-1:0]  sel_i,
    input  logic [ADDR_W_P-1:0] rd_data_i,
    output logic [SEL_W_P-1:0]  rd_addr_o,
    output logic [ADDR_W_P-1:0] base_o
);

    localparam logic [SEL_W_P-1:0] SP_SEL = SEL_W_P'(SP_REG_P);

    // Stack modes always read the stack pointer word.
    assign rd_addr_o = is_stack(mode_i) ? SP_SEL : sel_i;

    generate
        if (ZERO_REG_P) begin : g_zero_reg
            assign base_o = (rd_addr_o == '0) ? '0 : rd_data_i;
        end else begin : g_plain_reg
            assign base_o = rd_data_i;
        end
    endgenerate

endmodule

// File: rtl/eag_align_chk.sv
`timescale 1ns/1ps
module eag_align_chk
    import eag_pkg::*;
#(
    parameter int unsigned ADDR_W_P    = ADDR_W,
    parameter int unsigned DWORD_LSB_P = 2
) (
    input  logic [ADDR_W_P-1:0] addr_i,
    input  osize_e              size_i,
    input  logic                check_i,
    output logic                fault_o
);

    localparam logic [ADDR_W_P-1:0] WORD_MASK  = ADDR_W_P'(1);
    localparam logic [ADDR_W_P-1:0] DWORD_MASK = ADDR_W_P'((1 << DWORD_LSB_P) - 1);

    logic [ADDR_W_P-1:0] mask;

    always_comb begin
        unique case (size_i)
            SZ_BYTE:            mask = '0;
            SZ_WORD:            mask = WORD_MASK;
            SZ_DWORD, SZ_DWRD2: mask = DWORD_MASK;
        endcase
    end

    assign fault_o = check_i && ((addr_i & mask) != '0);

endmodule

// File: rtl/eag_calc.sv
`timescale 1ns/1ps
module eag_calc
    import eag_pkg::*;
#(
    parameter int unsigned ADDR_W_P  = ADDR_W,
    parameter int unsigned SEL_W_P   = SEL_W,
    parameter int unsigned SP_STEP_P = SP_STEP
) (
    input  amode_e              mode_i,
    input  logic [SEL_W_P-1:0]  sel_i,
    input  logic [ADDR_W_P-1:0] disp_i,
    input  osize_e              size_i,
    input  logic [ADDR_W_P-1:0] base_i,
    output logic [ADDR_W_P-1:0] ea_o,
    output logic [ADDR_W_P-1:0] sp_next_o,
    output logic                imm_o,
    output logic                sp_we_o,
    output logic                fault_o
);

    localparam int unsigned SHORT_W = 8;
    localparam logic [ADDR_W_P-1:0] STEP = ADDR_W_P'(SP_STEP_P);

    logic [ADDR_W_P-1:0] short_disp;
    logic                check;
    osize_e              chk_size;

    assign short_disp = {{(ADDR_W_P-SHORT_W){disp_i[SHORT_W-1]}}, disp_i[SHORT_W-1:0]};

    always_comb begin
        ea_o      = '0;
        sp_next_o = '0;
        imm_o     = 1'b0;
        sp_we_o   = 1'b0;
        check     = 1'b1;
        chk_size  = size_i;
        unique case (mode_i)
            AM_DIRECT, AM_RSVD: ea_o = ADDR_W_P'(sel_i);
            AM_INDIRECT:        ea_o = base_i;
            AM_IMMED: begin
                imm_o = 1'b1;
                check = 1'b0;
                ea_o  = (size_i == SZ_BYTE) ? ADDR_W_P'(disp_i[SHORT_W-1:0]) : disp_i;
            end
            AM_SHORT:           ea_o = base_i + short_disp;
            AM_LONG:            ea_o = base_i + disp_i;
            AM_PUSH: begin
                ea_o      = base_i - STEP;
                sp_next_o = base_i - STEP;
                sp_we_o   = 1'b1;
                chk_size  = SZ_WORD;
            end
            AM_POP: begin
                ea_o      = base_i;
                sp_next_o = base_i + STEP;
                sp_we_o   = 1'b1;
                chk_size  = SZ_WORD;
            end
        endcase
    end

    eag_align_chk #(
        .ADDR_W_P    (ADDR_W_P),
        .DWORD_LSB_P (2)
    ) u_align (
        .addr_i  (ea_o),
        .size_i  (chk_size),
        .check_i (check),
        .fault_o (fault_o)
    );

endmodule

// File: rtl/operand_addr_gen.sv
`timescale 1ns/1ps
module operand_addr_gen
    import eag_pkg::*;
#(
    parameter int unsigned ADDR_W_P  = ADDR_W,
    parameter int unsigned SEL_W_P   = SEL_W,
    parameter int unsigned SP_REG_P  = SP_REG,
    parameter int unsigned SP_STEP_P = SP_STEP
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [2:0]          mode_i,
    input  logic [SEL_W_P-1:0]  reg_sel_i,
    input  logic [ADDR_W_P-1:0] disp_i,
    input  logic [1:0]          size_i,
    output logic [SEL_W_P-1:0]  rf_addr_o,
    input  logic [ADDR_W_P-1:0] rf_data_i,
    output logic                busy_o,
    output logic                done_o,
    output logic [ADDR_W_P-1:0] ea_o,
    output logic                imm_flag_o,
    output logic                align_fault_o,
    output logic                access_o,
    output logic [ADDR_W_P-1:0] sp_next_o,
    output logic                sp_we_o
);

    eag_state_e          state_q, state_d;
    amode_e              mode_q;
    logic [SEL_W_P-1:0]  sel_q;
    logic [ADDR_W_P-1:0] disp_q;
    osize_e              size_q;
    logic [ADDR_W_P-1:0] base_w, base_q;

    logic [ADDR_W_P-1:0] c_ea, c_sp;
    logic                c_imm, c_spwe, c_fault;

    logic                done_q, imm_q, fault_q, access_q, spwe_q;
    logic [ADDR_W_P-1:0] ea_q, sp_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state: accept, capture, retire
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = ST_READ;
            ST_READ: state_d = ST_CALC;
            ST_CALC: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Request and base capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= AM_DIRECT;
            sel_q  <= '0;
            disp_q <= '0;
            size_q <= SZ_BYTE;
            base_q <= '0;
        end else begin
            if (state_q == ST_IDLE && start_i) begin
                mode_q <= amode_e'(mode_i);
                sel_q  <= reg_sel_i;
                disp_q <= disp_i;
                size_q <= osize_e'(size_i);
            end
            if (state_q == ST_READ) base_q <= base_w;
        end
    end

    eag_base_sel #(
        .ADDR_W_P   (ADDR_W_P),
        .SEL_W_P    (SEL_W_P),
        .SP_REG_P   (SP_REG_P),
        .ZERO_REG_P (1'b1)
    ) u_base (
        .mode_i    (mode_q),
        .sel_i     (sel_q),
        .rd_data_i (rf_data_i),
        .rd_addr_o (rf_addr_o),
        .base_o    (base_w)
    );

    eag_calc #(
        .ADDR_W_P  (ADDR_W_P),
        .SEL_W_P   (SEL_W_P),
        .SP_STEP_P (SP_STEP_P)
    ) u_calc (
        .mode_i    (mode_q),
        .sel_i     (sel_q),
        .disp_i    (disp_q),
        .size_i    (size_q),
        .base_i    (base_q),
        .ea_o      (c_ea),
        .sp_next_o (c_sp),
        .imm_o     (c_imm),
        .sp_we_o   (c_spwe),
        .fault_o   (c_fault)
    );

    // Output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q   <= 1'b0;
            access_q <= 1'b0;
            spwe_q   <= 1'b0;
            imm_q    <= 1'b0;
            fault_q  <= 1'b0;
            ea_q     <= '0;
            sp_q     <= '0;
        end else begin
            done_q   <= 1'b0;
            access_q <= 1'b0;
            spwe_q   <= 1'b0;
            if (state_q == ST_CALC) begin
                done_q   <= 1'b1;
                access_q <= !c_fault;
                spwe_q   <= c_spwe && !c_fault;
                imm_q    <= c_imm;
                fault_q  <= c_fault;
                ea_q     <= c_ea;
                sp_q     <= c_sp;
            end
        end
    end

    assign busy_o        = (state_q != ST_IDLE);
    assign done_o        = done_q;
    assign access_o      = access_q;
    assign sp_we_o       = spwe_q;
    assign imm_flag_o    = imm_q;
    assign align_fault_o = fault_q;
    assign ea_o          = ea_q;
    assign sp_next_o     = sp_q;

    // Assertions
    a_r1_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r1_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start_i) |=> (state_q == ST_READ && busy_o));

    a_r1_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READ) |-> ##2 done_o);

    a_r7_zero_base: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READ && rf_addr_o == '0) |=> (base_q == '0));

    a_r9_push_sp: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && sp_we_o && mode_q == AM_PUSH) |-> (sp_next_o == ea_o));

    a_r10_pop_sp: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && sp_we_o && mode_q == AM_POP) |-> (sp_next_o == ea_o + ADDR_W_P'(SP_STEP_P)));

    a_r11_fault_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && align_fault_o) |-> (!access_o && !sp_we_o));

    a_r4_imm_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && imm_flag_o) |-> !align_fault_o);

endmodule

// File: tb/operand_addr_gen_bench.sv
`timescale 1ns/1ps
module operand_addr_gen_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  mode = '0;
    logic [7:0]  sel = '0;
    logic [15:0] disp = '0;
    logic [1:0]  size = '0;
    logic [7:0]  rf_addr;
    logic [15:0] rf_data;
    logic        busy, done, imm, fault, access, sp_we;
    logic [15:0] ea, sp_next;

    logic [15:0] rf_mem [256];
    int          n_chk = 0;
    int          n_bad = 0;
    bit          finished = 1'b0;

    always #2 clk = ~clk;

    assign rf_data = rf_mem[rf_addr];

    operand_addr_gen u_operand_addr_gen (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start),
        .mode_i        (mode),
        .reg_sel_i     (sel),
        .disp_i        (disp),
        .size_i        (size),
        .rf_addr_o     (rf_addr),
        .rf_data_i     (rf_data),
        .busy_o        (busy),
        .done_o        (done),
        .ea_o          (ea),
        .imm_flag_o    (imm),
        .align_fault_o (fault),
        .access_o      (access),
        .sp_next_o     (sp_next),
        .sp_we_o       (sp_we)
    );

    // {mode, sel, disp, size, exp_ea, exp_imm, exp_fault, pad}
    localparam int NV = 17;
    localparam logic [63:0] VEC [NV] = '{
        {3'd0, 8'h21, 16'h0000, 2'd0, 16'h0021, 1'b0, 1'b0, 17'd0}, // R2
        {3'd0, 8'h21, 16'h0000, 2'd1, 16'h0021, 1'b0, 1'b1, 17'd0}, // R2 R11
        {3'd1, 8'h20, 16'h0000, 2'd1, 16'h2000, 1'b0, 1'b0, 17'd0}, // R3
        {3'd1, 8'h34, 16'h0000, 2'd1, 16'h1001, 1'b0, 1'b1, 17'd0}, // R3 R11
        {3'd1, 8'h34, 16'h0000, 2'd0, 16'h1001, 1'b0, 1'b0, 17'd0}, // R11 byte
        {3'd2, 8'h00, 16'hABCD, 2'd0, 16'h00CD, 1'b1, 1'b0, 17'd0}, // R4
        {3'd2, 8'h00, 16'hABCD, 2'd1, 16'hABCD, 1'b1, 1'b0, 17'd0}, // R4
        {3'd3, 8'h20, 16'h007F, 2'd0, 16'h207F, 1'b0, 1'b0, 17'd0}, // R5
        {3'd3, 8'h20, 16'h0080, 2'd0, 16'h1F80, 1'b0, 1'b0, 17'd0}, // R5
        {3'd3, 8'h20, 16'h12FE, 2'd1, 16'h1FFE, 1'b0, 1'b0, 17'd0}, // R5
        {3'd3, 8'h30, 16'h00F0, 2'd0, 16'hFFF5, 1'b0, 1'b0, 17'd0}, // R8
        {3'd4, 8'h20, 16'h1234, 2'd1, 16'h3234, 1'b0, 1'b0, 17'd0}, // R6
        {3'd4, 8'h00, 16'h5678, 2'd1, 16'h5678, 1'b0, 1'b0, 17'd0}, // R7
        {3'd4, 8'h32, 16'h0004, 2'd2, 16'h0002, 1'b0, 1'b1, 17'd0}, // R8 R11
        {3'd4, 8'h32, 16'h0006, 2'd2, 16'h0004, 1'b0, 1'b0, 17'd0}, // R8 R6
        {3'd1, 8'h00, 16'h0000, 2'd1, 16'h0000, 1'b0, 1'b0, 17'd0}, // R7
        {3'd4, 8'h20, 16'h0082, 2'd3, 16'h2082, 1'b0, 1'b1, 17'd0}  // R11
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [2:0] m, input logic [7:0] s,
                          input logic [15:0] d, input logic [1:0] z);
        @(negedge clk);
        mode = m; sel = s; disp = d; size = z; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) rf_mem[i] = {i[7:0], 8'h00};
        rf_mem[8'h00] = 16'hBEEF;
        rf_mem[8'h30] = 16'h0005;
        rf_mem[8'h32] = 16'hFFFE;
        rf_mem[8'h34] = 16'h1001;
        rf_mem[8'h18] = 16'h0100;

        // R12: reset state
        repeat (2) @(negedge clk);
        chk("R12 done",  {15'd0, done},  16'd0);
        chk("R12 busy",  {15'd0, busy},  16'd0);
        chk("R12 ea",    ea,             16'd0);
        chk("R12 sp",    sp_next,        16'd0);
        chk("R12 flags", {12'd0, imm, fault, access, sp_we}, 16'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12 after", {14'd0, done, busy}, 16'd0);

        // Vector table
        for (int v = 0; v < NV; v++) begin
            run_op(VEC[v][63:61], VEC[v][60:53], VEC[v][52:37], VEC[v][36:35]);
            chk("R1 done",   {15'd0, done},   16'd1);
            chk("R2-6 ea",   ea,              VEC[v][34:19]);
            chk("R4 imm",    {15'd0, imm},    {15'd0, VEC[v][18]});
            chk("R11 fault", {15'd0, fault},  {15'd0, VEC[v][17]});
            chk("R11 access",{15'd0, access}, {15'd0, ~VEC[v][17]});
            chk("R11 spwe",  {15'd0, sp_we},  16'd0);
        end

        // R9: push from 0x0100
        run_op(3'd5, 8'h55, 16'h0000, 2'd0);
        chk("R9 ea",   ea,      16'h00FE);
        chk("R9 sp",   sp_next, 16'h00FE);
        chk("R9 we",   {15'd0, sp_we}, 16'd1);
        if (sp_we) rf_mem[8'h18] = sp_next;

        // R10: pop twice
        run_op(3'd6, 8'h00, 16'h0000, 2'd2);
        chk("R10 ea",  ea,      16'h00FE);
        chk("R10 sp",  sp_next, 16'h0100);
        chk("R10 we",  {15'd0, sp_we}, 16'd1);
        if (sp_we) rf_mem[8'h18] = sp_next;
        run_op(3'd6, 8'h00, 16'h0000, 2'd0);
        chk("R10 ea2", ea,      16'h0100);
        chk("R10 sp2", sp_next, 16'h0102);
        if (sp_we) rf_mem[8'h18] = sp_next;

        // R11: push with odd stack pointer faults, no writeback
        rf_mem[8'h18] = 16'h0101;
        run_op(3'd5, 8'h00, 16'h0000, 2'd0);
        chk("R11 push ea",    ea, 16'h00FF);
        chk("R11 push fault", {15'd0, fault}, 16'd1);
        chk("R11 push we",    {15'd0, sp_we}, 16'd0);
        chk("R11 push acc",   {15'd0, access}, 16'd0);

        // R1: start held while busy is ignored
        @(negedge clk);
        mode = 3'd1; sel = 8'h20; disp = 16'h0000; size = 2'd1; start = 1'b1;
        @(negedge clk);
        chk("R1 busy", {15'd0, busy}, 16'd1);
        mode = 3'd4; disp = 16'h1234;
        @(negedge clk);
        start = 1'b0;
        chk("R1 no early done", {15'd0, done}, 16'd0);
        @(negedge clk);
        chk("R1 done", {15'd0, done}, 16'd1);
        chk("R1 first result kept", ea, 16'h2000);
        @(negedge clk);
        chk("R1 single pulse", {15'd0, done}, 16'd0);
        chk("R1 idle", {15'd0, busy}, 16'd0);
        repeat (3) @(negedge clk);
        chk("R1 no second done", {15'd0, done}, 16'd0);
        chk("R1 ea held", ea, 16'h2000);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule